// File: doc/BRIEF.md
# Memory Protection Region Checker

This block holds the settings of four memory protection regions and judges every bus access against them in the same cycle. Each region has a base address, a power-of-two size chosen by a 5-bit code, an enable, eight subregion disables, an access-permission code, an execute-never flag and stored memory-type bits. An incoming access carries an address, a read/write flag, an instruction-fetch flag and a privilege flag. The block reports whether an enabled region claims the address, which region won, and whether the access breaks that region's permissions.

Software programs the regions through a small register port. A region-number register picks which region the base and attribute registers refer to. Every register write must be privileged. Each write carries a two-bit halfword mask, so either 16-bit half of a register can be updated alone. The attribute word keeps a fixed bit layout because fault-handling software decodes it.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset every region's attribute word and base address read as zero, the region number reads as zero, and no address is reported as a hit.
- R2: A register write with `cfg_priv` low changes no register.
- R3: `cfg_half[1]` enables writing bits 31:16 and `cfg_half[0]` enables writing bits 15:0 of the selected register; a half whose mask bit is clear keeps its value.
- R4: Register select `cfg_sel` is 0 for the region number (bits 1:0), 1 for the base address (bits 31:5 stored, 4:0 read zero), 2 for the attribute word and 3 reads zero. Attribute layout: XN bit 28, AP 26:24, TEX 21:19, S 18, C 17, B 16, SRD 15:8, SIZE 5:1, ENABLE 0; every other bit reads zero.
- R5: A region spans 2^(SIZE+1) bytes; SIZE codes 0 to 3 are illegal and such a region never hits.
- R6: SIZE code 31 makes the region cover the whole 4 GB address space whatever its base.
- R7: With N = SIZE+1, an enabled region hits when address bits 31:N equal base bits 31:N.
- R8: For SIZE 7 or larger, address bits N-1:N-3 select one of eight subregions; a set SRD bit at that index removes the address from the region.
- R9: For SIZE 4 to 6 (128 bytes or less) the SRD field has no effect on hits.
- R10: When several regions hit, the highest-numbered one wins; `acc_hit` and `acc_region` report the winner independent of `acc_valid`.
- R11: AP code 1 allows only privileged accesses, 2 allows privileged accesses and unprivileged reads, 3 allows everything, and any other code allows nothing; a disallowed access with `acc_valid` high raises `acc_fault`.
- R12: An instruction fetch that hits a region with XN set raises `acc_fault`, whatever the AP code; a fetch otherwise counts as a read.
- R13: `acc_fault` is low whenever `acc_valid` is low or no enabled region hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_priv | input | 1 | Write comes from privileged code |
| cfg_sel | input | 2 | Register select (number, base, attributes) |
| cfg_half | input | 2 | Halfword write mask, bit 1 upper, bit 0 lower |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register, combinational |
| acc_valid | input | 1 | Bus access present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_hit | output | 1 | An enabled region claims the address |
| acc_region | output | 2 | Winning region number |
| acc_fault | output | 1 | Permission fault |

## Verification
On every cycle the assertions hold that unprivileged writes leave all state untouched, that reserved attribute bits read zero, that a fault never appears without a valid access and a hit, that the reported region is the highest hitting one, that execute-never fetches fault and that full-access regions never fault. Whether the size decoding, base alignment and subregion indexing place boundaries at the right addresses can only be shown by the bench's sweeps across region edges and subregion borders, compared against an arithmetic model of the requirements, as can the halfword merge results and the reset values read back.

// File: rtl/mpu_guard_pkg.sv
// Shared types and constants of the memory protection region checker.
// Assumes a 32-bit register word; the attribute layout is fixed because
// fault-handling software decodes it.
package mpu_guard_pkg;

    // Region attribute fields held per region (24 bits of state).
    typedef struct packed {
        logic       xn;
        logic [2:0] ap;
        logic [2:0] tex;
        logic       s;
        logic       c;
        logic       b;
        logic [7:0] srd;
        logic [4:0] size;
        logic       en;
    } region_attr_t;

    // Register select codes of the configuration port.
    typedef enum logic [1:0] {
        SEL_NUM  = 2'd0,
        SEL_BASE = 2'd1,
        SEL_ATTR = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    // Access permission codes.
    localparam logic [2:0] AP_NONE    = 3'd0;
    localparam logic [2:0] AP_PRIV    = 3'd1;
    localparam logic [2:0] AP_USER_RO = 3'd2;
    localparam logic [2:0] AP_FULL    = 3'd3;

    localparam int          REG_W        = 32;
    localparam int          BASE_LSB     = 5;
    localparam logic [4:0]  SIZE_MIN     = 5'd4;
    localparam logic [4:0]  SIZE_SUB_MIN = 5'd7;
    localparam logic [31:0] ATTR_RW_MASK = 32'h173F_FF3F;

    // Place the attribute fields at their register bit positions.
    function automatic logic [REG_W-1:0] pack_attr(input region_attr_t a);
        return {3'b000, a.xn, 1'b0, a.ap, 2'b00, a.tex, a.s, a.c, a.b,
                a.srd, 2'b00, a.size, a.en};
    endfunction

    // Pull the attribute fields out of a register word, dropping reserved bits.
    function automatic region_attr_t unpack_attr(input logic [REG_W-1:0] w);
        region_attr_t a;
        a.xn   = w[28];
        a.ap   = w[26:24];
        a.tex  = w[21:19];
        a.s    = w[18];
        a.c    = w[17];
        a.b    = w[16];
        a.srd  = w[15:8];
        a.size = w[5:1];
        a.en   = w[0];
        return a;
    endfunction

    // Combine an old and a new register word under a halfword mask.
    function automatic logic [REG_W-1:0] merge_half(input logic [REG_W-1:0] old_w,
                                                    input logic [REG_W-1:0] new_w,
                                                    input logic [1:0]       half);
        return {half[1] ? new_w[31:16] : old_w[31:16],
                half[0] ? new_w[15:0]  : old_w[15:0]};
    endfunction

endpackage

// File: rtl/mpu_region_regs.sv
// Configuration register file: region-number select, per-region base
// address and per-region attribute word. Writes need privilege and apply
// per halfword. Assumes ADDR_W equals the 32-bit register word.
module mpu_region_regs
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         cfg_wr,
    input  logic                                         cfg_priv,
    input  logic [1:0]                                   cfg_sel,
    input  logic [1:0]                                   cfg_half,
    input  logic [REG_W-1:0]                             cfg_wdata,
    output logic [REG_W-1:0]                             cfg_rdata,
    output region_attr_t [NUM_REGIONS-1:0]               attr_o,
    output logic [NUM_REGIONS-1:0][ADDR_W-BASE_LSB-1:0]  base_o
);

    localparam int NUM_W  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
    localparam int BASE_W = ADDR_W - BASE_LSB;

    logic [NUM_W-1:0]                        num_q;
    region_attr_t [NUM_REGIONS-1:0]          attr_q;
    logic [NUM_REGIONS-1:0][BASE_W-1:0]      base_q;
    logic                                    wr_ok;
    logic [REG_W-1:0]                        base_word;
    logic [REG_W-1:0]                        attr_word;
    logic [REG_W-1:0]                        base_merged;
    logic [REG_W-1:0]                        attr_merged;

    // Qualify writes: only privileged writes reach the registers.
    assign wr_ok = cfg_wr && cfg_priv;

    // Current words of the selected region and their merged replacements.
    always_comb begin
        base_word   = {base_q[num_q], {BASE_LSB{1'b0}}};
        attr_word   = pack_attr(attr_q[num_q]);
        base_merged = merge_half(base_word, cfg_wdata, cfg_half);
        attr_merged = merge_half(attr_word, cfg_wdata, cfg_half);
    end

    // Register update with synchronous reset to an all-disabled state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q  <= '0;
            attr_q <= '0;
            base_q <= '0;
        end else if (wr_ok) begin
            case (cfg_sel)
                SEL_NUM:  if (cfg_half[0]) num_q <= cfg_wdata[NUM_W-1:0];
                SEL_BASE: base_q[num_q] <= base_merged[ADDR_W-1:BASE_LSB];
                SEL_ATTR: attr_q[num_q] <= unpack_attr(attr_merged);
                default:  ;
            endcase
        end
    end

    // Read mux for the selected register.
    always_comb begin
        case (cfg_sel)
            SEL_NUM:  cfg_rdata = {{(REG_W-NUM_W){1'b0}}, num_q};
            SEL_BASE: cfg_rdata = base_word;
            SEL_ATTR: cfg_rdata = attr_word;
            default:  cfg_rdata = '0;
        endcase
    end

    assign attr_o = attr_q;
    assign base_o = base_q;

    AST_UNPRIV_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_priv) |=> ($stable(attr_q) && $stable(base_q) && $stable(num_q))); // R2

    AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == SEL_ATTR) |-> ((cfg_rdata & ~ATTR_RW_MASK) == '0)); // R4

    AST_RESET_ALL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (attr_q == '0 && num_q == '0)); // R1

endmodule

// File: rtl/mpu_region_match.sv
// Address match of one region: size decode, aligned base compare and
// subregion exclusion. Purely combinational. Assumes a 32-bit address map
// so that the largest size code spans it entirely.
module mpu_region_match
    import mpu_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  region_attr_t                  attr_i,
    input  logic [ADDR_W-BASE_LSB-1:0]    base_i,
    input  logic [ADDR_W-1:0]             addr_i,
    output logic                          hit_o
);

    localparam int SH_W = $clog2(ADDR_W) + 1;

    logic [SH_W-1:0]   span_log2;
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] sub_shift;
    logic [2:0]        sub_idx;
    logic              size_legal;
    logic              addr_in_span;
    logic              sub_supported;
    logic              sub_excluded;

    // Size decode: region spans 2^(SIZE+1) bytes; small codes are illegal.
    always_comb begin
        span_log2  = SH_W'(attr_i.size) + SH_W'(1);
        size_legal = (attr_i.size >= SIZE_MIN);
        keep_mask  = {ADDR_W{1'b1}} << span_log2;
    end

    // Base compare above the region's alignment (whole map when mask is zero).
    always_comb begin
        base_full    = {base_i, {BASE_LSB{1'b0}}};
        addr_in_span = ((addr_i ^ base_full) & keep_mask) == '0;
    end

    // Subregion index from the three bits below the alignment boundary.
    always_comb begin
        sub_shift     = addr_i >> (span_log2 - SH_W'(3));
        sub_idx       = sub_shift[2:0];
        sub_supported = (attr_i.size >= SIZE_SUB_MIN);
        sub_excluded  = sub_supported && attr_i.srd[sub_idx];
    end

    // Final region hit.
    assign hit_o = attr_i.en && size_legal && addr_in_span && !sub_excluded;

endmodule

// File: rtl/mpu_perm_eval.sv
// Picks the highest-numbered hitting region and judges the access against
// its permission code and execute-never flag. Combinational; the clock and
// reset serve only the embedded checks.
module mpu_perm_eval
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_REGIONS-1:0]          hits_i,
    input  region_attr_t [NUM_REGIONS-1:0]  attr_i,
    input  logic                            valid_i,
    input  logic                            write_i,
    input  logic                            fetch_i,
    input  logic                            priv_i,
    output logic                            hit_o,
    output logic [((NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1)-1:0] region_o,
    output logic                            fault_o
);

    localparam int NUM_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    region_attr_t win_attr;
    logic         allowed;

    // Priority select: later (higher) regions overwrite earlier ones.
    always_comb begin
        hit_o    = 1'b0;
        region_o = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits_i[i]) begin
                hit_o    = 1'b1;
                region_o = NUM_W'(i);
            end
        end
        win_attr = attr_i[region_o];
    end

    // Permission decode of the winning region's access code.
    always_comb begin
        case (win_attr.ap)
            AP_PRIV:    allowed = priv_i;
            AP_USER_RO: allowed = priv_i || !write_i;
            AP_FULL:    allowed = 1'b1;
            default:    allowed = 1'b0;
        endcase
    end

    // Fault on a valid access that hits without permission or fetches from XN.
    assign fault_o = valid_i && hit_o && (!allowed || (win_attr.xn && fetch_i));

    AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (valid_i && (hits_i != '0))); // R13

    AST_WINNER_IS_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (hits_i[region_o] && ((hits_i >> region_o) >> 1) == '0)); // R10

    AST_XN_FETCH_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && hit_o && fetch_i && attr_i[region_o].xn) |-> fault_o); // R12

    AST_FULL_ACCESS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && attr_i[region_o].ap == AP_FULL && !attr_i[region_o].xn) |-> !fault_o); // R11

endmodule

// File: rtl/mpu_region_guard.sv
// Top of the memory protection region checker: configuration registers,
// one address matcher per region, and the priority/permission stage.
// Access results are combinational from the access inputs and register state.
module mpu_region_guard
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_priv,
    input  logic [1:0]  cfg_sel,
    input  logic [1:0]  cfg_half,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic        acc_write,
    input  logic        acc_fetch,
    input  logic        acc_priv,
    output logic        acc_hit,
    output logic [1:0]  acc_region,
    output logic        acc_fault
);

    localparam int BASE_W = ADDR_W - BASE_LSB;

    region_attr_t [NUM_REGIONS-1:0]      attr_all;
    logic [NUM_REGIONS-1:0][BASE_W-1:0]  base_all;
    logic [NUM_REGIONS-1:0]              hits;

    mpu_region_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_priv  (cfg_priv),
        .cfg_sel   (cfg_sel),
        .cfg_half  (cfg_half),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .attr_o    (attr_all),
        .base_o    (base_all)
    );

    // One matcher per region.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        mpu_region_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .attr_i (attr_all[g]),
            .base_i (base_all[g]),
            .addr_i (acc_addr),
            .hit_o  (hits[g])
        );
    end

    mpu_perm_eval #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_perm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hits_i   (hits),
        .attr_i   (attr_all),
        .valid_i  (acc_valid),
        .write_i  (acc_write),
        .fetch_i  (acc_fetch),
        .priv_i   (acc_priv),
        .hit_o    (acc_hit),
        .region_o (acc_region),
        .fault_o  (acc_fault)
    );

endmodule

// File: tb/mpu_region_guard_test.sv
// Self-checking bench: register checks, then address sweeps over two region
// configurations compared against an arithmetic model of the requirements.
module mpu_region_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_priv = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [1:0]  cfg_half = 2'b00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        acc_priv = 1'b0;
    logic        acc_hit;
    logic [1:0]  acc_region;
    logic        acc_fault;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] sh_base [4];
    logic [31:0] sh_attr [4];

    always #10 clk = ~clk;

    mpu_region_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_priv(cfg_priv),
        .cfg_sel(cfg_sel), .cfg_half(cfg_half), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_priv(acc_priv),
        .acc_hit(acc_hit), .acc_region(acc_region), .acc_fault(acc_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (addr=%h)", tag, act, exp, acc_addr);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [1:0] half,
                             input logic [31:0] data, input logic priv);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_half = half; cfg_wdata = data; cfg_priv = priv;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_priv = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [31:0] data);
        @(negedge clk);
        cfg_sel = sel;
        #2 data = cfg_rdata;
    endtask

    // Program one region fully and mirror it in the shadow model.
    task automatic set_region(input int r, input logic [31:0] base, input logic [31:0] attr);
        cfg_write(2'd0, 2'b11, r, 1'b1);
        cfg_write(2'd1, 2'b11, base, 1'b1);
        cfg_write(2'd2, 2'b11, attr, 1'b1);
        sh_base[r] = base & 32'hFFFF_FFE0;
        sh_attr[r] = attr & 32'h173F_FF3F;
    endtask

    // Expected outcome computed from the requirement text.
    function automatic void model(input logic [31:0] a, input logic v, input logic w,
                                  input logic f, input logic p, output logic hit,
                                  output logic [1:0] rg, output logic flt);
        logic ok;
        hit = 1'b0; rg = 2'd0;
        for (int r = 0; r < 4; r++) begin
            int sz;
            int n;
            sz = int'(sh_attr[r][5:1]);
            n  = sz + 1;
            if (!sh_attr[r][0] || sz < 4) continue;
            if (n < 32 && (a >> n) != (sh_base[r] >> n)) continue;
            if (sz >= 7 && sh_attr[r][8 + int'((a >> (n - 3)) & 32'd7)]) continue;
            hit = 1'b1; rg = 2'(r);
        end
        case (sh_attr[rg][26:24])
            3'd1:    ok = p;
            3'd2:    ok = p || !w;
            3'd3:    ok = 1'b1;
            default: ok = 1'b0;
        endcase
        flt = v && hit && (!ok || (sh_attr[rg][28] && f));
    endfunction

    task automatic probe(input logic [31:0] a, input logic v, input logic w,
                         input logic f, input logic p, input string hit_tag);
        logic eh;
        logic [1:0] er;
        logic ef;
        @(negedge clk);
        acc_addr = a; acc_valid = v; acc_write = w; acc_fetch = f; acc_priv = p;
        #2;
        model(a, v, w, f, p, eh, er, ef);
        check(hit_tag, 32'(acc_hit), 32'(eh));
        if (eh) check("R10 winning region", 32'(acc_region), 32'(er));
        check("R11 fault", 32'(acc_fault), 32'(ef));
    endtask

    task automatic sweep(input logic [31:0] start, input int count, input logic [31:0] step,
                         input string hit_tag);
        for (int i = 0; i < count; i++) begin
            for (int t = 0; t < 8; t++) begin
                probe(start + step * i, 1'b1, t[0], t[1], t[2], hit_tag);
            end
        end
    endtask

    initial begin
        logic [31:0] rd;
        for (int r = 0; r < 4; r++) begin sh_base[r] = '0; sh_attr[r] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and no hits.
        cfg_read(2'd0, rd); check("R1 region number", rd, 32'h0);
        for (int r = 0; r < 4; r++) begin
            cfg_write(2'd0, 2'b01, r, 1'b1);
            cfg_read(2'd1, rd); check("R1 base", rd, 32'h0);
            cfg_read(2'd2, rd); check("R1 attributes", rd, 32'h0);
        end
        probe(32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, "R1 no hit");
        probe(32'hFFFF_FFFC, 1'b1, 1'b1, 1'b1, 1'b1, "R1 no hit");

        // R2: unprivileged writes do nothing.
        cfg_write(2'd0, 2'b11, 32'h0, 1'b1);
        cfg_write(2'd2, 2'b11, 32'h0300_003F, 1'b0);
        cfg_read(2'd2, rd); check("R2 attr unchanged", rd, 32'h0);
        cfg_write(2'd1, 2'b11, 32'h1234_5678, 1'b0);
        cfg_read(2'd1, rd); check("R2 base unchanged", rd, 32'h0);
        cfg_write(2'd0, 2'b11, 32'h3, 1'b0);
        cfg_read(2'd0, rd); check("R2 number unchanged", rd, 32'h0);
        probe(32'h0000_0040, 1'b1, 1'b1, 1'b0, 1'b0, "R2 still disabled");

        // R3 / R4: halfword masks and reserved bits.
        cfg_write(2'd2, 2'b10, 32'hFFFF_FFFF, 1'b1);
        cfg_read(2'd2, rd); check("R3 upper half only", rd, 32'h173F_0000);
        cfg_write(2'd2, 2'b01, 32'hFFFF_FFFF, 1'b1);
        cfg_read(2'd2, rd); check("R4 all writable bits", rd, 32'h173F_FF3F);
        cfg_write(2'd2, 2'b10, 32'h0000_0000, 1'b1);
        cfg_read(2'd2, rd); check("R3 lower half kept", rd, 32'h0000_FF3F);
        cfg_write(2'd2, 2'b00, 32'h0000_0000, 1'b1);
        cfg_read(2'd2, rd); check("R3 no half written", rd, 32'h0000_FF3F);
        cfg_write(2'd2, 2'b11, 32'h0, 1'b1);
        cfg_write(2'd1, 2'b11, 32'hFFFF_FFFF, 1'b1);
        cfg_read(2'd1, rd); check("R4 base low bits zero", rd, 32'hFFFF_FFE0);
        cfg_write(2'd1, 2'b01, 32'h0000_0000, 1'b1);
        cfg_read(2'd1, rd); check("R3 base upper kept", rd, 32'hFFFF_0000);
        cfg_write(2'd1, 2'b11, 32'h0, 1'b1);
        cfg_write(2'd0, 2'b11, 32'h2, 1'b1);
        cfg_read(2'd0, rd); check("R4 region number", rd, 32'h2);
        cfg_read(2'd3, rd); check("R4 unused select", rd, 32'h0);

        // Configuration A: overlapping regions, subregions, small regions.
        set_region(1, 32'h2000_0000, 32'h0100_8113);  // 1 KB, AP1, SRD 0x81
        set_region(2, 32'h2000_0100, 32'h1200_FF09);  // 32 B, AP2, XN, SRD ignored
        set_region(3, 32'h2000_0200, 32'h0000_FF0D);  // 128 B, AP0, SRD ignored
        sweep(32'h1FFF_FF80, 320, 32'd4, "R7 hit");
        sweep(32'h2000_0000, 8, 32'h80, "R8 subregion hit");
        probe(32'h2000_0110, 1'b1, 1'b0, 1'b1, 1'b1, "R9 small region hit");
        check("R9 region two wins", 32'(acc_region), 32'd2);
        check("R12 XN fetch fault", 32'(acc_fault), 32'd1);
        probe(32'h2000_0110, 1'b1, 1'b0, 1'b0, 1'b0, "R9 small region hit");
        check("R11 user read allowed", 32'(acc_fault), 32'd0);
        probe(32'h2000_0110, 1'b1, 1'b1, 1'b0, 1'b0, "R9 small region hit");
        check("R11 user write refused", 32'(acc_fault), 32'd1);
        probe(32'h2000_0250, 1'b1, 1'b0, 1'b0, 1'b1, "R9 128 B region hit");
        check("R11 no-access code faults", 32'(acc_fault), 32'd1);
        probe(32'h2000_0250, 1'b0, 1'b0, 1'b0, 1'b1, "R13 invalid access");
        check("R13 no fault without valid", 32'(acc_fault), 32'd0);
        probe(32'h3000_0000, 1'b1, 1'b1, 1'b1, 1'b0, "R13 outside all regions");
        check("R13 no fault without hit", 32'(acc_fault), 32'd0);

        // Configuration B: whole-map region and illegal size code.
        set_region(1, 32'h0000_0000, 32'h0000_0005);  // SIZE 2: illegal
        set_region(2, 32'h0, 32'h0);
        set_region(3, 32'h0, 32'h0);
        set_region(0, 32'hABCD_E000, 32'h1300_043F);  // 4 GB, AP3, XN, SRD bit 2
        probe(32'h0000_0010, 1'b1, 1'b1, 1'b0, 1'b0, "R5 illegal size ignored");
        check("R5 region zero wins", 32'(acc_region), 32'd0);
        probe(32'h4000_0004, 1'b1, 1'b0, 1'b0, 1'b0, "R8 whole-map subregion");
        check("R8 excluded subregion", 32'(acc_hit), 32'd0);
        sweep(32'h0000_0010, 64, 32'h0400_0000, "R6 whole map hit");
        set_region(1, 32'h0000_0000, 32'h0000_0007);  // SIZE 3: illegal
        probe(32'h0000_0004, 1'b1, 1'b1, 1'b0, 1'b0, "R5 size three ignored");
        check("R5 region zero still wins", 32'(acc_region), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule